// File: doc/BRIEF.md
# Asynchronous Serial Receive Unit

This block turns an asynchronous serial line into characters. A separate rate generator supplies a strobe at twice the bit rate (a half-bit tick). The receiver resynchronises the line, waits for a falling edge, and checks again at the next half-bit tick that the line is still low. Only then does it accept a start bit. It then samples every data bit, the optional parity bit and the stop bit near the middle of each bit. Each completed character is placed in a buffer register, and any fault is recorded in a three-bit error status.

A six-bit control word sets the operating mode: unit enable, receive enable, character length, parity mode and interrupt routing for errors. Two single-cycle interrupt pulses report results. One signals a received character. The other signals a receive error, unless routing sends errors to the receive interrupt as well. Surrounding logic reads the buffer and the status with single-cycle read strobes. Reading the status clears it.

Top module: `async_rx_unit`

## Requirements
- R1: With control bit 2 set a character carries DATA_W (8) data bits, least significant first. With it clear it carries DATA_W-1 (7) bits, and the top buffer bit reads 0.
- R2: Control bits 4:3 select parity: 00 none (the stop bit follows the last data bit), 01 zero, 10 odd, 11 even. A parity bit follows the data in every mode other than none, and a correct frame leaves the status at 0.
- R3: Status bit 2 is set when the parity bit is wrong. Zero mode expects 0. Odd mode expects an odd count of ones over data and parity. Even mode expects an even count.
- R4: Status bit 1 is set when the line is low at the stop-bit sample point.
- R5: Status bit 0 is set when a character completes while the buffer still holds a character that has not been read. The new character replaces the old one.
- R6: A character with any error pulses irq_err_o, and not irq_rx_o, when control bit 5 is 0. It pulses irq_rx_o, and not irq_err_o, when control bit 5 is 1. The two interrupts never pulse together.
- R7: Reception happens only while control bit 0 (unit enable) and control bit 1 (receive enable) are both 1. Otherwise a frame on the line changes neither the buffer, the status nor the interrupts.
- R8: Every completed character is loaded into rx_data_o, whether or not it has an error. An error-free character pulses irq_rx_o for one cycle.
- R9: Error bits stay set until a status read (rd_stat_i). They clear on that read, while new errors in the same cycle still set their bits.
- R10: A low pulse on the line that has ended before the next half-bit tick is rejected. It produces no character and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| ctrl_i | input | 6 | Control word: 0 unit enable, 1 receive enable, 2 full length, 4:3 parity mode, 5 route errors to irq_rx_o |
| hb_tick_i | input | 1 | Half-bit-period strobe from the rate generator |
| rxd_i | input | 1 | Serial line, idle high |
| rd_data_i | input | 1 | Buffer read strobe, marks the buffer as consumed |
| rd_stat_i | input | 1 | Status read strobe, clears the error bits |
| rx_data_o | output | DATA_W | Most recently received character |
| err_stat_o | output | 3 | Error flags: 2 parity, 1 framing, 0 overrun |
| irq_rx_o | output | 1 | Receive-complete interrupt pulse |
| irq_err_o | output | 1 | Receive-error interrupt pulse |

## Verification
The routing checks assume the control word is stable during a character. The interrupt checks compare against the control value from the cycle before the pulse. The enable check takes the two cycles of pipeline between the framer and the interrupt registers into account. The stimulus meets these assumptions by changing ctrl_i only while the line is idle between frames. It also holds the line stable across each half-bit tick: it drives the line just after a tick and holds each bit for two ticks, so every sample lands in the middle of a bit.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   typedef enum logic [2:0] {
      ST_HUNT, ST_IDLE, ST_START, ST_DATA, ST_PARB, ST_STOP
   } rx_state_e;

   typedef enum logic [1:0] {
      PAR_NONE = 2'd0, PAR_ZERO = 2'd1, PAR_ODD = 2'd2, PAR_EVEN = 2'd3
   } par_mode_e;

   localparam int CTL_W      = 6;
   localparam int CTL_UNIT   = 0;
   localparam int CTL_RXEN   = 1;
   localparam int CTL_LEN    = 2;
   localparam int CTL_PAR_LO = 3;
   localparam int CTL_ROUTE  = 5;

   localparam int ERR_W   = 3;
   localparam int ERR_OVR = 0;
   localparam int ERR_FRM = 1;
   localparam int ERR_PAR = 2;

   // ones_odd: reduction xor of the received data bits
   function automatic logic par_error(par_mode_e m, logic ones_odd, logic pbit);
      case (m)
         PAR_ZERO: return pbit;
         PAR_ODD:  return ~(ones_odd ^ pbit);
         PAR_EVEN: return ones_odd ^ pbit;
         default:  return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '1;
      else         q <= {q[STAGES-2:0], d_i};
   end

   assign q_o = q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
   import serial_rx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              len_full_i,
   input  par_mode_e         pmode_i,
   input  logic              hb_tick_i,
   input  logic              line_i,
   output logic              done_o,
   output logic [DATA_W-1:0] data_o,
   output logic              perr_o,
   output logic              ferr_o
);
   localparam int CNT_W = $clog2(DATA_W);

   rx_state_e         state;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  last;
   logic              ph;
   logic [DATA_W-1:0] sh;

   assign last = len_full_i ? CNT_W'(DATA_W - 1) : CNT_W'(DATA_W - 2);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state  <= ST_HUNT;
         cnt    <= '0;
         ph     <= 1'b0;
         sh     <= '0;
         done_o <= 1'b0;
         perr_o <= 1'b0;
         ferr_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (!en_i) begin
            state <= ST_HUNT;
         end else begin
            case (state)
               ST_HUNT: if (line_i) state <= ST_IDLE;
               ST_IDLE: if (!line_i) state <= ST_START;
               ST_START: if (hb_tick_i) begin
                  if (!line_i) begin
                     state  <= ST_DATA;
                     cnt    <= '0;
                     ph     <= 1'b0;
                     sh     <= '0;
                     perr_o <= 1'b0;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
               ST_DATA: if (hb_tick_i) begin
                  ph <= ~ph;
                  if (ph) begin
                     sh[cnt] <= line_i;
                     if (cnt == last)
                        state <= (pmode_i == PAR_NONE) ? ST_STOP : ST_PARB;
                     else
                        cnt <= cnt + 1'b1;
                  end
               end
               ST_PARB: if (hb_tick_i) begin
                  ph <= ~ph;
                  if (ph) begin
                     perr_o <= par_error(pmode_i, ^sh, line_i);
                     state  <= ST_STOP;
                  end
               end
               ST_STOP: if (hb_tick_i) begin
                  ph <= ~ph;
                  if (ph) begin
                     ferr_o <= ~line_i;
                     done_o <= 1'b1;
                     state  <= ST_HUNT;
                  end
               end
               default: state <= ST_HUNT;
            endcase
         end
      end
   end

   assign data_o = sh;
endmodule

// File: rtl/rx_status.sv
module rx_status
   import serial_rx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              done_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              perr_i,
   input  logic              ferr_i,
   input  logic              route_i,
   input  logic              rd_data_i,
   input  logic              rd_stat_i,
   output logic [DATA_W-1:0] buf_o,
   output logic [ERR_W-1:0]  stat_o,
   output logic              irq_rx_o,
   output logic              irq_err_o
);
   logic             full;
   logic [ERR_W-1:0] err_new;
   logic             any_err;

   always_comb begin
      err_new          = '0;
      err_new[ERR_PAR] = done_i & perr_i;
      err_new[ERR_FRM] = done_i & ferr_i;
      err_new[ERR_OVR] = done_i & full & ~rd_data_i;
   end

   assign any_err = |err_new;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         buf_o     <= '0;
         stat_o    <= '0;
         full      <= 1'b0;
         irq_rx_o  <= 1'b0;
         irq_err_o <= 1'b0;
      end else begin
         if (done_i) buf_o <= data_i;
         full      <= done_i | (full & ~rd_data_i);
         stat_o    <= (rd_stat_i ? '0 : stat_o) | err_new;
         irq_rx_o  <= done_i & (~any_err | route_i);
         irq_err_o <= done_i & any_err & ~route_i;
      end
   end
endmodule

// File: rtl/async_rx_unit.sv
module async_rx_unit
   import serial_rx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [5:0]        ctrl_i,
   input  logic              hb_tick_i,
   input  logic              rxd_i,
   input  logic              rd_data_i,
   input  logic              rd_stat_i,
   output logic [DATA_W-1:0] rx_data_o,
   output logic [2:0]        err_stat_o,
   output logic              irq_rx_o,
   output logic              irq_err_o
);
   if (DATA_W < 2 || DATA_W > 16) begin : g_bad_width
      $error("async_rx_unit: DATA_W must lie in 2..16");
   end
   if (SYNC_STAGES == 1 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("async_rx_unit: SYNC_STAGES must be 0 or 2..4");
   end

   logic              line_s;
   logic              en;
   logic              fr_done;
   logic [DATA_W-1:0] fr_data;
   logic              fr_perr;
   logic              fr_ferr;

   assign en = ctrl_i[CTL_UNIT] & ctrl_i[CTL_RXEN];

   if (SYNC_STAGES == 0) begin : g_nosync
      assign line_s = rxd_i;
   end else begin : g_sync
      rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .d_i   (rxd_i),
         .q_o   (line_s)
      );
   end

   rx_framer #(.DATA_W(DATA_W)) i_framer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en),
      .len_full_i(ctrl_i[CTL_LEN]),
      .pmode_i   (par_mode_e'(ctrl_i[CTL_PAR_LO+1:CTL_PAR_LO])),
      .hb_tick_i (hb_tick_i),
      .line_i    (line_s),
      .done_o    (fr_done),
      .data_o    (fr_data),
      .perr_o    (fr_perr),
      .ferr_o    (fr_ferr)
   );

   rx_status #(.DATA_W(DATA_W)) i_status (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .done_i   (fr_done),
      .data_i   (fr_data),
      .perr_i   (fr_perr),
      .ferr_i   (fr_ferr),
      .route_i  (ctrl_i[CTL_ROUTE]),
      .rd_data_i(rd_data_i),
      .rd_stat_i(rd_stat_i),
      .buf_o    (rx_data_o),
      .stat_o   (err_stat_o),
      .irq_rx_o (irq_rx_o),
      .irq_err_o(irq_err_o)
   );
endmodule

// File: rtl/async_rx_unit_chk.sv
module async_rx_unit_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       unit_en,
   input logic       rx_en,
   input logic       route,
   input logic       rd_stat_i,
   input logic [2:0] err_stat_o,
   input logic       irq_rx_o,
   input logic       irq_err_o
);
   AST_IRQ_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(irq_rx_o && irq_err_o)); // R6

   AST_ERR_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_err_o |-> !$past(route)); // R6

   AST_ERR_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_err_o |-> (err_stat_o != 3'b000)); // R6

   AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(rd_stat_i) |-> ((err_stat_o & $past(err_stat_o)) == $past(err_stat_o))); // R9

   AST_STAT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rd_stat_i) && !irq_rx_o && !irq_err_o) |-> (err_stat_o == 3'b000)); // R9

   AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_rx_o || irq_err_o) |-> $past(unit_en && rx_en, 2)); // R7

   AST_OVR_WITH_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_stat_o[0]) |-> (irq_rx_o || irq_err_o)); // R5
endmodule

bind async_rx_unit async_rx_unit_chk i_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .unit_en   (ctrl_i[0]),
   .rx_en     (ctrl_i[1]),
   .route     (ctrl_i[5]),
   .rd_stat_i (rd_stat_i),
   .err_stat_o(err_stat_o),
   .irq_rx_o  (irq_rx_o),
   .irq_err_o (irq_err_o)
);

// File: tb/test_async_rx_unit.sv
module test_async_rx_unit;
   localparam int HT = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] ctrl = 6'h00;
   logic       hb_tick;
   logic       rxd = 1'b1;
   logic       rd_data = 1'b0;
   logic       rd_stat = 1'b0;
   logic [7:0] rx_data;
   logic [2:0] err_stat;
   logic       irq_rx;
   logic       irq_err;

   int checks = 0;
   int errors = 0;
   int n_rx = 0;
   int n_err = 0;
   int tcnt = 0;

   always #2 clk = ~clk;

   always @(negedge clk) tcnt <= (tcnt == HT - 1) ? 0 : tcnt + 1;
   assign hb_tick = (tcnt == HT - 1);

   always @(posedge clk) begin
      if (irq_rx)  n_rx  <= n_rx + 1;
      if (irq_err) n_err <= n_err + 1;
   end

   async_rx_unit i_async_rx_unit (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .ctrl_i    (ctrl),
      .hb_tick_i (hb_tick),
      .rxd_i     (rxd),
      .rd_data_i (rd_data),
      .rd_stat_i (rd_stat),
      .rx_data_o (rx_data),
      .err_stat_o(err_stat),
      .irq_rx_o  (irq_rx),
      .irq_err_o (irq_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick_wait();
      do @(posedge clk); while (!hb_tick);
      #1;
   endtask

   task automatic hold(input logic v, input int n);
      rxd = v;
      for (int k = 0; k < n; k++) tick_wait();
   endtask

   function automatic logic exp_pbit(input logic [7:0] d, input int pm);
      case (pm)
         1: return 1'b0;
         2: return ~^d;
         3: return ^d;
         default: return 1'b0;
      endcase
   endfunction

   task automatic send(input logic [7:0] d, input int nb, input int pm,
                       input logic flip, input logic stop_v);
      logic [7:0] dm;
      dm = (nb == 8) ? d : (d & 8'h7f);
      tick_wait();
      hold(1'b0, 2);
      for (int i = 0; i < nb; i++) hold(dm[i], 2);
      if (pm != 0) hold(exp_pbit(dm, pm) ^ flip, 2);
      hold(stop_v, 2);
      hold(1'b1, 4);
   endtask

   task automatic rd_buf();
      @(negedge clk); rd_data = 1'b1;
      @(negedge clk); rd_data = 1'b0;
   endtask

   task automatic rd_st();
      @(negedge clk); rd_stat = 1'b1;
      @(negedge clk); rd_stat = 1'b0;
   endtask

   task automatic set_ctrl(input logic [5:0] c);
      @(negedge clk); ctrl = c;
   endtask

   initial begin
      #400000;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] pats [5] = '{8'h00, 8'hff, 8'ha5, 8'h3c, 8'h81};
      int r0, e0;
      logic [7:0] held;

      repeat (5) @(posedge clk);
      #1;
      chk("reset R8 buffer", int'(rx_data), 0);
      chk("reset R9 status", int'(err_stat), 0);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);

      // R1 R2 R8: sweep lengths, parity modes and data patterns
      for (int len = 0; len < 2; len++) begin
         for (int pm = 0; pm < 4; pm++) begin
            for (int p = 0; p < 5; p++) begin
               set_ctrl(6'(3 | (len << 2) | (pm << 3)));
               r0 = n_rx; e0 = n_err;
               send(pats[p], len ? 8 : 7, pm, 1'b0, 1'b1);
               @(negedge clk);
               chk("R1 data", int'(rx_data), int'(len ? pats[p] : (pats[p] & 8'h7f)));
               chk("R2 clean status", int'(err_stat), 0);
               chk("R8 irq_rx pulse", (n_rx - r0) * 16 + (n_err - e0), 16);
               rd_buf();
               rd_st();
            end
         end
      end

      // R3 R6: wrong parity in each mode with both routings
      for (int pm = 1; pm < 4; pm++) begin
         for (int rt = 0; rt < 2; rt++) begin
            set_ctrl(6'(3 | 4 | (pm << 3) | (rt << 5)));
            r0 = n_rx; e0 = n_err;
            send(8'h5a, 8, pm, 1'b1, 1'b1);
            @(negedge clk);
            chk("R3 parity flag", int'(err_stat), 4);
            chk("R6 routing", (n_rx - r0) * 16 + (n_err - e0), rt ? 16 : 1);
            chk("R8 errored char loaded", int'(rx_data), 8'h5a);
            rd_buf();
            rd_st();
            @(negedge clk);
            chk("R9 cleared by read", int'(err_stat), 0);
         end
      end

      // R4: low stop bit
      set_ctrl(6'b000111);
      e0 = n_err;
      send(8'h33, 8, 0, 1'b0, 1'b0);
      @(negedge clk);
      chk("R4 framing flag", int'(err_stat), 2);
      chk("R4 error irq", n_err - e0, 1);
      rd_buf();

      // R9: flag survives a later good frame, clears on status read
      send(8'h44, 8, 0, 1'b0, 1'b1);
      @(negedge clk);
      chk("R9 sticky", int'(err_stat), 2);
      rd_buf();
      rd_st();
      @(negedge clk);
      chk("R9 clear", int'(err_stat), 0);

      // R5: second character without reading the first
      e0 = n_err;
      send(8'h11, 8, 0, 1'b0, 1'b1);
      send(8'h22, 8, 0, 1'b0, 1'b1);
      @(negedge clk);
      chk("R5 overrun flag", int'(err_stat), 1);
      chk("R5 overwrite", int'(rx_data), 8'h22);
      chk("R5 error irq", n_err - e0, 1);
      rd_buf();
      rd_st();

      // R10: short glitch
      held = rx_data;
      r0 = n_rx; e0 = n_err;
      tick_wait();
      rxd = 1'b0;
      repeat (2) @(posedge clk);
      #1 rxd = 1'b1;
      for (int k = 0; k < 8; k++) tick_wait();
      @(negedge clk);
      chk("R10 no irq", (n_rx - r0) + (n_err - e0), 0);
      chk("R10 buffer kept", int'(rx_data), int'(held));

      // R7: either enable bit clear blocks reception
      for (int v = 0; v < 2; v++) begin
         set_ctrl(v ? 6'b000101 : 6'b000110);
         r0 = n_rx; e0 = n_err;
         send(8'hc3, 8, 0, 1'b0, 1'b0);
         @(negedge clk);
         chk("R7 no irq when off", (n_rx - r0) + (n_err - e0), 0);
         chk("R7 buffer kept", int'(rx_data), int'(held));
         chk("R7 status kept", int'(err_stat), 0);
      end
      set_ctrl(6'b000111);
      r0 = n_rx;
      send(8'hc3, 8, 0, 1'b0, 1'b1);
      @(negedge clk);
      chk("R7 re-enabled", int'(rx_data), 8'hc3);
      chk("R7 re-enabled irq", n_rx - r0, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule